// File: doc/BRIEF.md
# Return-to-Zero Serial Word Transmitter with Eight-Word Buffer

This block takes parallel words from a host, holds up to eight of them in a first-in first-out buffer, and sends each one as a serial frame on a pair of return-to-zero line-drive outputs. The outputs are meant for an external differential line driver. The high output signals a logic 1 and the low output signals a logic 0. Each bit cell lasts ten clocks: the selected output is driven for the first five clocks, and both outputs stay at null for the last five. The block generates a parity bit for every frame, sends it as the final bit, and places a null gap of at least four bit times between consecutive frames without any host action.

A frame is either 32 or 25 bits long, chosen by `short_word`. In both lengths the last bit is parity and every earlier bit is taken from the buffered word, least significant bit first. `par_even` selects the parity sense. The length and the parity sense are both captured at the moment a word leaves the buffer. A sequencer with three states moves the words. IDLE waits for work. The transition IDLE→SEND occurs when `tx_en` is high and the buffer holds a word; that word is popped and framed at that moment. SEND shifts out bit cells. SEND→GAP occurs at the end of the last bit cell. GAP counts the null interval. GAP→IDLE occurs when that count completes, and IDLE then starts the next word if the conditions still hold.

Top module: `awt_tx`

## Requirements
- R1: After reset both line outputs are 0 and `fifo_full` is 0.
- R2: The buffer accepts eight writes while nothing is being sent, and `fifo_full` is 1 once it holds eight words.
- R3: A write while `fifo_full` is 1 is ignored, and the buffered words are unchanged. `fifo_full` stays 1 until a word is taken, and is 0 at the first falling clock edge after the rising edge at which a word leaves for transmission.
- R4: A word starts only while `tx_en` is 1 and the buffer is not empty. While `tx_en` is 0, no pulse appears on either output.
- R5: If `tx_en` falls during a word, that word still completes, and no further word starts until `tx_en` returns to 1.
- R6: Each bit cell is 10 clocks long. `drv_one` (for a 1) or `drv_zero` (for a 0) is high for exactly 5 clocks, followed by 5 clocks of null. The two outputs are never high together.
- R7: Bits go out least significant first. With `short_word`=0 the frame is data bits 0..30 and then parity (32 bits). With `short_word`=1 it is data bits 0..23 and then parity (25 bits). Data bits above those positions have no effect.
- R8: With `par_even`=0 the frame carries an odd number of ones, parity included. With `par_even`=1 it carries an even number.
- R9: Between consecutive frames the outputs stay null for at least 45 clocks from the end of the last pulse, which is the rest of the last cell plus four bit times. Buffered words are sent one after another, without host action, until the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at ten times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_data | input | 32 | Word to buffer |
| fifo_full | output | 1 | Buffer holds eight words |
| tx_en | input | 1 | Permits new words to start |
| par_even | input | 1 | 0 selects odd parity, 1 selects even parity |
| short_word | input | 1 | 0 selects 32-bit frames, 1 selects 25-bit frames |
| drv_one | output | 1 | Return-to-zero pulse for a 1 bit |
| drv_zero | output | 1 | Return-to-zero pulse for a 0 bit |

## Verification
The hardest state to reach is a full buffer that stays full while a ninth write arrives, followed by the exact edge at which the flag clears. From the ports this requires holding `tx_en` low while the bench loads eight words, pushing an extra word, and then raising `tx_en` at a known falling edge. The bench then decodes every pulse train back into words, which shows that the extra word never appears. A separate directed case drops `tx_en` part-way through a frame. Random rounds with a fixed seed vary the frame length, the parity sense, the burst size and writes made during streaming, and each decoded frame is compared with a frame the bench builds itself.

// File: rtl/awt_pkg.sv
package awt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } awt_state_e;
endpackage

// File: rtl/awt_fifo.sv
module awt_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr;
    logic          do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds the buffer depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3: a write into a full buffer with no read leaves occupancy unchanged
    a_r3_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && $stable(wr_ptr)));

    // R3: a read from a full buffer clears the flag on the next cycle
    a_r3_full_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_en) |=> !full);
endmodule

// File: rtl/awt_frame.sv
module awt_frame #(
    parameter int W       = 32,
    parameter int SHORT_W = 25
) (
    input  logic                     [W-1:0] data,
    input  logic                             short_sel,
    input  logic                             par_even,
    output logic                     [W-1:0] frame,
    output logic [$clog2(W + 1)-1:0]         nbits
);
    localparam int NBW = $clog2(W + 1);

    int   len;
    logic par;

    always_comb begin
        len   = short_sel ? SHORT_W : W;
        par   = ~par_even;
        frame = '0;
        for (int i = 0; i < W; i++) begin
            if (i < len - 1) begin
                frame[i] = data[i];
                par      = par ^ data[i];
            end
        end
        for (int i = 0; i < W; i++) begin
            if (i == len - 1) begin
                frame[i] = par;
            end
        end
        nbits = NBW'(len);
    end
endmodule

// File: rtl/awt_seq.sv
module awt_seq
    import awt_pkg::*;
#(
    parameter int W    = 32,
    parameter int CPB  = 10,
    parameter int GAP  = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_en,
    input  logic                     fifo_empty,
    input  logic [W-1:0]             frame,
    input  logic [$clog2(W + 1)-1:0] nbits,
    output logic                     pop,
    output logic                     drv_one,
    output logic                     drv_zero
);
    localparam int HALF = CPB / 2;
    localparam int CB   = $clog2(CPB);
    localparam int GB   = (GAP > 1) ? $clog2(GAP) : 1;
    localparam int BB   = $clog2(W);

    awt_state_e    state;
    awt_state_e    state_nx;
    logic [CB-1:0] cnt;
    logic [GB-1:0] gcnt;
    logic [BB-1:0] bidx;
    logic [BB-1:0] last_idx;
    logic [W-1:0]  shreg;
    logic          start;
    logic          cell_end;
    logic          bit_last;
    logic          gap_end;
    logic          in_pulse;

    assign start    = (state == ST_IDLE) && tx_en && !fifo_empty;
    assign cell_end = (cnt == CB'(CPB - 1));
    assign bit_last = (bidx == last_idx);
    assign gap_end  = (gcnt == GB'(GAP - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)                state_nx = ST_SEND;
            ST_SEND: if (cell_end && bit_last) state_nx = ST_GAP;
            ST_GAP:  if (gap_end)              state_nx = ST_IDLE;
            default:                           state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            gcnt     <= '0;
            bidx     <= '0;
            last_idx <= '0;
            shreg    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        shreg    <= frame;
                        last_idx <= BB'(nbits - 1'b1);
                        bidx     <= '0;
                        cnt      <= '0;
                    end
                end
                ST_SEND: begin
                    gcnt <= '0;
                    if (cell_end) begin
                        cnt   <= '0;
                        bidx  <= bidx + 1'b1;
                        shreg <= shreg >> 1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    gcnt <= gcnt + 1'b1;
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    always_comb begin
        in_pulse = (state == ST_SEND) && (cnt < CB'(HALF));
        drv_one  = in_pulse && shreg[0];
        drv_zero = in_pulse && !shreg[0];
        pop      = start;
    end

    // R6: the two line outputs are mutually exclusive
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_one && drv_zero));

    // R6: a pulse lasts more than one clock
    a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_one) |=> drv_one);

    // R4: without enable and data the sequencer stays idle
    a_r4_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(tx_en && !fifo_empty)) |=> (state == ST_IDLE));

    // R7: a frame ends only after its last bit cell
    a_r7_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_SEND && state == ST_GAP) |-> ($past(bidx) == $past(last_idx)));

    // R9: the gap state is left only after the full null count
    a_r9_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_GAP && state == ST_IDLE) |-> ($past(gcnt) == GB'(GAP - 1)));
endmodule

// File: rtl/awt_tx.sv
module awt_tx #(
    parameter int DATA_W      = 32,
    parameter int SHORT_W     = 25,
    parameter int FIFO_DEPTH  = 8,
    parameter int CLK_PER_BIT = 10,
    parameter int GAP_BITS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fifo_full,
    input  logic              tx_en,
    input  logic              par_even,
    input  logic              short_word,
    output logic              drv_one,
    output logic              drv_zero
);
    localparam int GAP_CLKS = GAP_BITS * CLK_PER_BIT;
    localparam int NBW      = $clog2(DATA_W + 1);

    logic              pop;
    logic              empty;
    logic [DATA_W-1:0] head;
    logic [DATA_W-1:0] frame;
    logic [NBW-1:0]    nbits;

    awt_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (head),
        .empty   (empty),
        .full    (fifo_full)
    );

    awt_frame #(
        .W       (DATA_W),
        .SHORT_W (SHORT_W)
    ) u_frame (
        .data      (head),
        .short_sel (short_word),
        .par_even  (par_even),
        .frame     (frame),
        .nbits     (nbits)
    );

    awt_seq #(
        .W   (DATA_W),
        .CPB (CLK_PER_BIT),
        .GAP (GAP_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .fifo_empty (empty),
        .frame      (frame),
        .nbits      (nbits),
        .pop        (pop),
        .drv_one    (drv_one),
        .drv_zero   (drv_zero)
    );
endmodule

// File: tb/awt_tx_tb.sv
`timescale 1ns/1ps
module awt_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        fifo_full;
    logic        tx_en = 1'b0;
    logic        par_even = 1'b0;
    logic        short_word = 1'b0;
    logic        drv_one;
    logic        drv_zero;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    int          hi_run = 0;
    int          lo_run = 1000;
    int          rx_n = 0;
    logic [31:0] rx_word = '0;
    logic        prev_act = 1'b0;
    int          words_seen = 0;
    int          pulses_seen = 0;

    always #4 clk = ~clk;

    awt_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .fifo_full  (fifo_full),
        .tx_en      (tx_en),
        .par_even   (par_even),
        .short_word (short_word),
        .drv_one    (drv_one),
        .drv_zero   (drv_zero)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input logic [31:0] d, input bit shrt, input bit even);
        logic p;
        if (shrt) begin
            p = (^d[23:0]) ^ ~even;
            return {7'b0, p, d[23:0]};
        end else begin
            p = (^d[30:0]) ^ ~even;
            return {p, d[30:0]};
        end
    endfunction

    // line monitor: decodes pulses back into frames
    always @(negedge clk) begin
        logic        act;
        logic [31:0] m;
        logic [31:0] d;
        int          len;
        if (rst_n) begin
            act = drv_one | drv_zero;
            if (drv_one && drv_zero) chk(1'b0, "R6 both high", 1, 0);
            if (act && !prev_act) begin
                pulses_seen++;
                if (rx_n > 0) chk(lo_run == 5, "R6 null half", lo_run, 5);
                else          chk(lo_run >= 45, "R9 gap", lo_run, 45);
                if (rx_n < 32) rx_word[rx_n] = drv_one;
                rx_n++;
                hi_run = 1;
            end else if (act) begin
                hi_run++;
            end
            if (!act && prev_act) chk(hi_run == 5, "R6 pulse width", hi_run, 5);
            if (act) lo_run = 0;
            else if (lo_run < 1000) lo_run++;
            if (!act && lo_run == 20 && rx_n > 0) begin
                len = short_word ? 25 : 32;
                m   = (len == 32) ? 32'hFFFF_FFFF : 32'h01FF_FFFF;
                chk(rx_n == len, "R7 bit count", rx_n, len);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected frame", rx_word, 0);
                end else begin
                    d = exp_q.pop_front();
                    chk((rx_word & m) == exp_frame(d, short_word, par_even), "R7 frame",
                        rx_word & m, exp_frame(d, short_word, par_even));
                    chk((^(rx_word & m)) == ~par_even, "R8 parity", ^(rx_word & m), ~par_even);
                end
                words_seen++;
                rx_n    = 0;
                rx_word = '0;
            end
            prev_act = act;
        end
    end

    task automatic put(input logic [31:0] d);
        @(negedge clk);
        if (!fifo_full) exp_q.push_back(d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || rx_n != 0) @(negedge clk);
        repeat (60) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drv_one == 1'b0, "R1 drv_one", drv_one, 0);
        chk(drv_zero == 1'b0, "R1 drv_zero", drv_zero, 0);
        chk(fifo_full == 1'b0, "R1 full", fifo_full, 0);

        // R4: buffered data but no enable -> silence
        put(32'h1234_5678);
        put(32'h0000_0000);
        put(32'h7FFF_FFFF);
        repeat (100) @(negedge clk);
        chk(pulses_seen == 0, "R4 no pulses while disabled", pulses_seen, 0);
        tx_en = 1'b1;
        drain();
        chk(words_seen == 3, "R9 back-to-back frames", words_seen, 3);

        // R2/R3: fill, overfill, release
        tx_en = 1'b0;
        base  = words_seen;
        for (int i = 0; i < 8; i++) put(32'hA000_0000 + i);
        chk(fifo_full == 1'b1, "R2 full at eight", fifo_full, 1);
        put(32'hDEAD_BEEF);
        repeat (20) @(negedge clk);
        chk(fifo_full == 1'b1, "R3 full held", fifo_full, 1);
        chk(exp_q.size() == 8, "R3 ninth ignored", exp_q.size(), 8);
        tx_en = 1'b1;
        @(negedge clk);
        chk(fifo_full == 1'b0, "R3 full clears after take", fifo_full, 0);
        drain();
        chk(words_seen == base + 8, "R3 eight frames out", words_seen - base, 8);

        // R5: drop enable mid-frame
        tx_en = 1'b0;
        base  = words_seen;
        put(32'h0F0F_0F0F);
        put(32'h3333_3333);
        put(32'h5555_AAAA);
        tx_en = 1'b1;
        while (pulses_seen == 0 || rx_n == 0) @(negedge clk);
        repeat (30) @(negedge clk);
        tx_en = 1'b0;
        repeat (600) @(negedge clk);
        chk(words_seen == base + 1, "R5 frame completes", words_seen - base, 1);
        chk(exp_q.size() == 2, "R5 no new start", exp_q.size(), 2);
        tx_en = 1'b1;
        drain();
        chk(words_seen == base + 3, "R5 resume", words_seen - base, 3);

        // R7/R8: short frames, even parity, upper bits ignored
        tx_en      = 1'b0;
        short_word = 1'b1;
        par_even   = 1'b1;
        put(32'hFFFF_FFFF);
        put(32'hFE00_0000);
        put(32'h00AA_5501);
        tx_en = 1'b1;
        drain();
        tx_en      = 1'b0;
        short_word = 1'b0;
        par_even   = 1'b0;
        put(32'h8000_0000);
        tx_en = 1'b1;
        drain();

        // random bursts
        for (int r = 0; r < 10; r++) begin
            int n;
            tx_en      = 1'b0;
            short_word = 1'($urandom % 2);
            par_even   = 1'($urandom % 2);
            n = 1 + ($urandom % 8);
            for (int k = 0; k < n; k++) put($urandom);
            tx_en = 1'b1;
            drain();
        end

        // streaming writes while sending, including writes into a full buffer
        short_word = 1'b0;
        par_even   = 1'b1;
        tx_en      = 1'b1;
        for (int k = 0; k < 20; k++) begin
            put($urandom);
            repeat ($urandom % 40) @(negedge clk);
        end
        drain();
        chk(drv_one == 1'b0 && drv_zero == 1'b0, "R9 idle after drain", {drv_one, drv_zero}, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule